// File: doc/BRIEF.md
# Serial Flash Identification Sequencer

This controller walks a serial flash through a fixed five-step identification script and keeps every answer in a result register of its own. A start pulse makes it turn the serial port on. It then runs five chip-select frames, one per step. Each frame carries a command byte, then zero to four address or dummy bytes of 0x00, then enough 0x00 filler bytes to clock in the response. When the last frame closes, the port is turned off and a one-cycle done pulse is given.

The shifting of bits is left to a byte engine outside the block. For each byte, the sequencer presents the byte and a one-cycle go strobe. It then waits for the engine's done strobe, which returns the byte clocked in from the flash. The sequencer drives chip select itself, so chip select stays low for a whole step rather than for a single byte. The five result words are the two-byte maker/device ID, the three-byte JEDEC ID, the eight-byte unique ID, and the first and second status bytes.

Top module: `flash_id_seq`

## Requirements
- R1: A start pulse while idle begins a run. A start pulse while a run is busy has no effect: the run still produces exactly five frames and the same results.
- R2: `port_en` rises in the cycle after an accepted start and stays high until the run ends. It is low whenever the block is idle.
- R3: `cs_n` is low only inside a step and goes high between any two steps. `byte_go` is only raised while `cs_n` is low and `port_en` is high.
- R4: The first byte of each frame is the step's command, in this fixed order: 0x90, 0x9F, 0x4B, 0x05, 0x35.
- R5: Frames carry 6, 4, 13, 2 and 2 bytes respectively. Every byte after the command byte is sent as 0x00.
- R6: Only one byte is outstanding at a time. After `byte_go`, no further `byte_go` is raised until `byte_done` has been seen.
- R7: Bytes received during the command and address or dummy bytes of a step are discarded. The 4, 1, 5, 1 and 1 leading bytes are dropped from steps 1 to 5. The response bytes are stored in arrival order, with the first byte in the most significant position of the step's result port.
- R8: `done` is high for exactly one cycle after step 5 completes. In that cycle `cs_n` is high and `port_en` is low.
- R9: An accepted start clears all five result ports to zero in the following cycle, before any step-1 byte is captured.
- R10: After reset, `cs_n` is high, `port_en`, `busy`, `done` and `byte_go` are low, and all result ports are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (ignored while busy) |
| byte_done | input | 1 | Engine finished the current byte |
| byte_rx | input | 8 | Byte clocked in by the engine, valid with `byte_done` |
| byte_go | output | 1 | Engine strobe: shift `byte_tx` |
| byte_tx | output | 8 | Byte to be shifted out |
| cs_n | output | 1 | Flash chip select, active low |
| port_en | output | 1 | Serial port enable |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| mfr_dev_id | output | 16 | Maker/device ID |
| jedec_id | output | 24 | JEDEC ID |
| unique_id | output | 64 | Unique ID |
| status1 | output | 8 | Status byte 1 |
| status2 | output | 8 | Status byte 2 |

## Verification
If the step counter or byte index goes wrong, the fault shows up at the ports within the same frame. The frame's command byte, its byte count, or where chip select rises would no longer match the script. A wrong capture window shifts or mixes bytes across the result ports, and this can be seen once `done` pulses. The bench sweeps several engine latency patterns and received-data seeds, and builds each expected result from the bytes it fed in. It also repeats runs to check the clear on restart and the rejection of a start while busy.

// File: rtl/flash_id_pkg.sv
package flash_id_pkg;
  localparam int BYTE_W  = 8;
  localparam int N_STEPS = 5;
  localparam int STEP_W  = $clog2(N_STEPS);
  localparam int MAX_LEN = 13;
  localparam int IDX_W   = $clog2(MAX_LEN + 1);
  localparam logic [BYTE_W-1:0] FILL = '0;

  typedef enum logic [2:0] {S_IDLE, S_PREP, S_ISSUE, S_WAIT, S_GAP} seq_state_e;

  function automatic logic [BYTE_W-1:0] step_cmd(input int s);
    case (s)
      0: return 8'h90;
      1: return 8'h9F;
      2: return 8'h4B;
      3: return 8'h05;
      default: return 8'h35;
    endcase
  endfunction

  // bytes sent before the response window (command plus address/dummy)
  function automatic int step_pre(input int s);
    case (s)
      0: return 4;
      2: return 5;
      default: return 1;
    endcase
  endfunction

  function automatic int step_rsp(input int s);
    case (s)
      0: return 2;
      1: return 3;
      2: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic int rsp_off(input int s);
    int acc = 0;
    for (int i = 0; i < s; i++) acc += step_rsp(i);
    return acc * BYTE_W;
  endfunction

  localparam int RES_W = rsp_off(N_STEPS);
endpackage

// File: rtl/flash_id_script.sv
module flash_id_script
  import flash_id_pkg::*;
(
  input  logic [STEP_W-1:0] step,
  output logic [BYTE_W-1:0] cmd,
  output logic [IDX_W-1:0]  pre_len,
  output logic [IDX_W-1:0]  last_idx
);
  always_comb begin
    cmd      = step_cmd(32'(step));
    pre_len  = IDX_W'(step_pre(32'(step)));
    last_idx = IDX_W'(step_pre(32'(step)) + step_rsp(32'(step)) - 1);
  end
endmodule

// File: rtl/flash_id_fsm.sv
module flash_id_fsm
  import flash_id_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] cmd,
  input  logic [IDX_W-1:0]  pre_len,
  input  logic [IDX_W-1:0]  last_idx,
  output logic [STEP_W-1:0] step,
  output logic              byte_go,
  output logic [BYTE_W-1:0] byte_tx,
  output logic              cs_n,
  output logic              port_en,
  output logic              busy,
  output logic              done,
  output logic              clr,
  output logic              cap_en
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              cs_n_q, cs_n_d;
  logic              pen_q, pen_d;
  logic              done_q, done_d;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    idx_d   = idx_q;
    cs_n_d  = cs_n_q;
    pen_d   = pen_q;
    done_d  = 1'b0;
    case (state_q)
      S_IDLE: if (start) begin
        pen_d   = 1'b1;
        step_d  = '0;
        idx_d   = '0;
        state_d = S_PREP;
      end
      S_PREP: begin
        cs_n_d  = 1'b0;
        state_d = S_ISSUE;
      end
      S_ISSUE: state_d = S_WAIT;
      S_WAIT: if (byte_done) begin
        if (idx_q == last_idx) begin
          cs_n_d  = 1'b1;
          state_d = S_GAP;
        end else begin
          idx_d   = idx_q + 1'b1;
          state_d = S_ISSUE;
        end
      end
      S_GAP: begin
        if (step_q == LAST_STEP) begin
          pen_d   = 1'b0;
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else begin
          step_d  = step_q + 1'b1;
          idx_d   = '0;
          state_d = S_PREP;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      idx_q   <= '0;
      cs_n_q  <= 1'b1;
      pen_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      idx_q   <= idx_d;
      cs_n_q  <= cs_n_d;
      pen_q   <= pen_d;
      done_q  <= done_d;
    end
  end

  assign step    = step_q;
  assign byte_go = (state_q == S_ISSUE);
  assign byte_tx = (idx_q == '0) ? cmd : FILL;
  assign cs_n    = cs_n_q;
  assign port_en = pen_q;
  assign busy    = (state_q != S_IDLE);
  assign done    = done_q;
  assign clr     = (state_q == S_IDLE) && start;
  assign cap_en  = (state_q == S_WAIT) && byte_done && (idx_q >= pre_len);

  p_go_needs_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_go |-> (!cs_n_q && pen_q));
  p_cs_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |=> cs_n_q);
  p_one_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_go |=> !byte_go);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cs_n_q && !pen_q));
  p_port_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE) |-> !pen_q);
endmodule

// File: rtl/flash_id_capture.sv
module flash_id_capture
  import flash_id_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cap_en,
  input  logic [STEP_W-1:0] step,
  input  logic [BYTE_W-1:0] rx,
  output logic [RES_W-1:0]  res
);
  for (genvar g = 0; g < N_STEPS; g++) begin : g_slot
    localparam int W   = BYTE_W * step_rsp(g);
    localparam int OFF = rsp_off(g);
    logic [W-1:0] slot_q, slot_d;
    logic         hit;

    assign hit = cap_en && (step == STEP_W'(g));

    if (W == BYTE_W) begin : g_single
      always_comb slot_d = rx;
    end else begin : g_multi
      always_comb slot_d = {slot_q[W-BYTE_W-1:0], rx};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_q <= '0;
      else if (clr) slot_q <= '0;
      else if (hit) slot_q <= slot_d;
    end

    assign res[OFF +: W] = slot_q;
  end

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (res == '0));
endmodule

// File: rtl/flash_id_seq.sv
module flash_id_seq
  import flash_id_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        byte_done,
  input  logic [7:0]  byte_rx,
  output logic        byte_go,
  output logic [7:0]  byte_tx,
  output logic        cs_n,
  output logic        port_en,
  output logic        busy,
  output logic        done,
  output logic [15:0] mfr_dev_id,
  output logic [23:0] jedec_id,
  output logic [63:0] unique_id,
  output logic [7:0]  status1,
  output logic [7:0]  status2
);
  logic [STEP_W-1:0] step;
  logic [BYTE_W-1:0] cmd;
  logic [IDX_W-1:0]  pre_len, last_idx;
  logic              clr, cap_en;
  logic [RES_W-1:0]  res;

  flash_id_script u_script (
    .step(step), .cmd(cmd), .pre_len(pre_len), .last_idx(last_idx)
  );

  flash_id_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_done(byte_done),
    .cmd(cmd), .pre_len(pre_len), .last_idx(last_idx), .step(step),
    .byte_go(byte_go), .byte_tx(byte_tx), .cs_n(cs_n), .port_en(port_en),
    .busy(busy), .done(done), .clr(clr), .cap_en(cap_en)
  );

  flash_id_capture u_cap (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cap_en(cap_en), .step(step),
    .rx(byte_rx), .res(res)
  );

  assign mfr_dev_id = res[rsp_off(0) +: 16];
  assign jedec_id   = res[rsp_off(1) +: 24];
  assign unique_id  = res[rsp_off(2) +: 64];
  assign status1    = res[rsp_off(3) +: 8];
  assign status2    = res[rsp_off(4) +: 8];

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !byte_go));
endmodule

// File: tb/test_flash_id_seq.sv
module test_flash_id_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic byte_done = 1'b0;
  logic [7:0] byte_rx = 8'h00;
  logic byte_go, cs_n, port_en, busy, done;
  logic [7:0] byte_tx, status1, status2;
  logic [15:0] mfr_dev_id;
  logic [23:0] jedec_id;
  logic [63:0] unique_id;

  always #10 clk = ~clk;

  flash_id_seq i_flash_id_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_done(byte_done),
    .byte_rx(byte_rx), .byte_go(byte_go), .byte_tx(byte_tx), .cs_n(cs_n),
    .port_en(port_en), .busy(busy), .done(done), .mfr_dev_id(mfr_dev_id),
    .jedec_id(jedec_id), .unique_id(unique_id), .status1(status1),
    .status2(status2)
  );

  int n_tests = 0, n_fail = 0;
  int seed = 0;
  int frame = 0, nbytes = 0, pend = 0;
  int bad_go = 0, overlap = 0, nz_fill = 0, done_cnt = 0, bad_done = 0;
  logic [7:0] pend_val = 8'h00;
  logic prev_cs = 1'b1;
  int fr_len [8];
  logic [7:0] fr_cmd [8];
  logic mon_on = 1'b0;

  localparam logic [7:0] CMDS [5] = '{8'h90, 8'h9F, 8'h4B, 8'h05, 8'h35};
  localparam int PRE [5] = '{4, 1, 5, 1, 1};
  localparam int RSP [5] = '{2, 3, 8, 1, 1};

  function automatic logic [7:0] rxv(int s, int f, int b);
    return 8'(s * 37 + f * 29 + b * 11 + 5);
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // engine model and port monitor in one process
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (prev_cs && !cs_n) nbytes = 0;
        if (!prev_cs && cs_n) begin
          if (frame < 8) fr_len[frame] = nbytes;
          frame++;
        end
        prev_cs = cs_n;
        if (done) begin
          done_cnt++;
          if (!cs_n || port_en) bad_done++;
        end
        byte_done = 1'b0;
        if (pend > 0) begin
          pend--;
          if (pend == 0) begin
            byte_done = 1'b1;
            byte_rx = pend_val;
          end
        end
        if (byte_go) begin
          if (cs_n || !port_en) bad_go++;
          if (pend > 0 || byte_done) overlap++;
          if (frame < 8) begin
            if (nbytes == 0) fr_cmd[frame] = byte_tx;
            else if (byte_tx != 8'h00) nz_fill++;
          end
          pend = 1 + ((seed + nbytes) % 4);
          pend_val = rxv(seed, frame, nbytes);
          nbytes++;
        end
      end
    end
  end

  task automatic run(int s, bit extra_start, bit chk_clear);
    logic [63:0] e;
    logic [63:0] got;
    int wd;
    seed = s; frame = 0; nbytes = 0; pend = 0; done_cnt = 0;
    bad_go = 0; overlap = 0; nz_fill = 0; bad_done = 0; prev_cs = cs_n;
    for (int i = 0; i < 8; i++) begin fr_len[i] = 0; fr_cmd[i] = 8'h00; end
    mon_on = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(port_en && busy, "R2 port_en after start", {62'd0, port_en, busy}, 64'd3);
    if (chk_clear)
      check(mfr_dev_id == 0 && jedec_id == 0 && unique_id == 0 && status1 == 0 && status2 == 0,
            "R9 results cleared", unique_id, 64'd0);
    if (extra_start) begin
      repeat (15) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wd = 0;
    while (done_cnt == 0 && wd < 2000) begin @(negedge clk); wd++; end
    check(wd < 2000, "watchdog", wd, 0);
    repeat (4) @(negedge clk);
    check(frame == 5, "R1 R4 frame count", frame, 5);
    for (int f = 0; f < 5; f++) begin
      check(fr_cmd[f] == CMDS[f], "R4 command byte", fr_cmd[f], CMDS[f]);
      check(fr_len[f] == PRE[f] + RSP[f], "R5 frame length", fr_len[f], PRE[f] + RSP[f]);
      e = 0;
      for (int b = 0; b < RSP[f]; b++) e = (e << 8) | 64'(rxv(s, f, PRE[f] + b));
      case (f)
        0: got = 64'(mfr_dev_id);
        1: got = 64'(jedec_id);
        2: got = unique_id;
        3: got = 64'(status1);
        default: got = 64'(status2);
      endcase
      check(got == e, "R7 captured result", got, e);
    end
    check(nz_fill == 0, "R5 filler bytes zero", nz_fill, 0);
    check(bad_go == 0, "R3 go outside frame", bad_go, 0);
    check(overlap == 0, "R6 outstanding bytes", overlap, 0);
    check(done_cnt == 1, "R8 done pulse count", done_cnt, 1);
    check(bad_done == 0, "R8 done with cs/port", bad_done, 0);
    check(!port_en && !busy && cs_n, "R2 idle after run", {61'd0, port_en, busy, cs_n}, 64'd1);
    mon_on = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n && !port_en && !busy && !done && !byte_go, "R10 reset controls",
          {59'd0, cs_n, port_en, busy, done, byte_go}, 64'h10);
    check(mfr_dev_id == 0 && jedec_id == 0 && unique_id == 0 && status1 == 0 && status2 == 0,
          "R10 reset results", unique_id, 64'd0);
    for (int s = 1; s <= 6; s++) run(s, s == 3, s > 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule